// File: doc/BRIEF.md
# Lane Margin Relay Register Block

This block sits on one receiver lane between a PCIe controller's lane-margining logic and the lane's PHY handler. While software has raised two ready flags, it watches the controller's margin control word and copies each new word into a holding register. It reports the first copy as a start event and any later, different copy as a change event. A stop command and a link arriving at 16 GT/s also raise events. Each event sets a bit in a write-one-to-clear event register. A mask register gates the bits onto a single level interrupt.

Software reads the held word and passes it to the PHY. It writes the PHY's error count into a status register, and that register drives the controller-side status output. A simple 32-bit register bus with byte offsets gives access to all registers. Reads come from combinational logic and writes take effect on the clock edge.

Top module: `lane_margin_relay`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `margin_status` is zero.
- R2: The event mask register at offset 0xE0 holds bits [3:0] as written, and its upper bits read zero. The event bit order is 0 readiness, 1 start, 2 change, 3 stop.
- R3: The first cycle in which `link_fast` is seen high after having been low sets event bit 0 at that clock edge.
- R4: Control words and stop commands are acted on only while bit 0 and bit 1 of the software status register at 0xE8 are both 1. Otherwise the held word stays unchanged and no start, change or stop event is raised.
- R5: The first capture after the ready bits are both set (or after a stop) loads the word and sets event bit 1. The event bit is set one clock after the held word updates.
- R6: A later word that differs from the held word is loaded and sets event bit 2 one clock later. A word equal to the held word raises no event.
- R7: `ctl_stop` sets event bit 3 one clock later and wins over a word strobed in the same cycle. The next capture after a stop is again reported as a start.
- R8: A write to 0xE4 clears each event bit whose data bit is 1. An event arriving at the same clock edge as its clear leaves the bit set.
- R9: `irq` is high exactly when some event bit and its mask bit are both 1.
- R10: A write to 0xF0 stores data bits [15:0]. They read back with zeros above, and `margin_status` shows them from the following cycle.
- R11: Offset 0xEC reads the held word, with enable at bit 0, clear at bit 1, X at bits [8:2], Y at [14:9] and block count at [22:15]. Writes to 0xEC have no effect.
- R12: The software status register at 0xE8 holds bits [3:0] as written. Any offset other than the five listed reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| ctl_vld | input | 1 | Controller presents a margin control word |
| ctl_word | input | 23 | Margin control word |
| ctl_stop | input | 1 | Controller issues a margin stop |
| link_fast | input | 1 | Link is running at 16 GT/s |
| irq | output | 1 | Level interrupt |
| margin_status | output | 16 | Status word returned to the controller |

## Verification
Directed sequences present the same word twice, a different word, a word while not ready, and a stop followed by a repeat of the held word. This separates a start from a change from silence and shows that a stop re-arms the start. A clear written in the same cycle as the re-raising change event separates set priority from clear priority. Random traffic mixes strobes from a small word pool, rare stops, toggling of the link and ready bits, and random register writes. It is checked every cycle against a bench model of events, mask and status.

// File: rtl/lmr_pkg.sv
package lmr_pkg;
  localparam int LMR_ADDR_W = 8;
  localparam int LMR_DATA_W = 32;
  localparam int LMR_EVT_N  = 4;
  localparam int LMR_STAT_W = 16;
  localparam int LMR_X_W    = 7;
  localparam int LMR_Y_W    = 6;
  localparam int LMR_NBLK_W = 8;
  localparam int LMR_CTL_W  = 2 + LMR_X_W + LMR_Y_W + LMR_NBLK_W;

  localparam logic [LMR_ADDR_W-1:0] OFS_EVT_MASK = 8'hE0;
  localparam logic [LMR_ADDR_W-1:0] OFS_EVT_RAW  = 8'hE4;
  localparam logic [LMR_ADDR_W-1:0] OFS_SW_FLAGS = 8'hE8;
  localparam logic [LMR_ADDR_W-1:0] OFS_HELD_CTL = 8'hEC;
  localparam logic [LMR_ADDR_W-1:0] OFS_MSTATUS  = 8'hF0;

  typedef enum int {EV_READY = 0, EV_START = 1, EV_CHANGE = 2, EV_STOP = 3} lmr_evt_e;

  // control word layout, enable in the least significant bit
  typedef struct packed {
    logic [LMR_NBLK_W-1:0] nblk;
    logic [LMR_Y_W-1:0]    y_off;
    logic [LMR_X_W-1:0]    x_off;
    logic                  clr;
    logic                  en;
  } lmr_ctl_t;

  function automatic lmr_ctl_t lmr_pack(input logic en, input logic clr,
                                        input logic [LMR_X_W-1:0] x,
                                        input logic [LMR_Y_W-1:0] y,
                                        input logic [LMR_NBLK_W-1:0] n);
    lmr_ctl_t c;
    c.en = en; c.clr = clr; c.x_off = x; c.y_off = y; c.nblk = n;
    return c;
  endfunction

  function automatic logic [LMR_EVT_N-1:0] lmr_w1c_next(input logic [LMR_EVT_N-1:0] cur,
                                                        input logic [LMR_EVT_N-1:0] clr,
                                                        input logic [LMR_EVT_N-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic lmr_flags_ready(input logic [LMR_EVT_N-1:0] flags);
    return flags[0] & flags[1];
  endfunction
endpackage

// File: rtl/lmr_link_watch.sv
module lmr_link_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic link_fast,
  output logic ready_pulse
);
  logic link_q;

  always_ff @(posedge clk) begin
    if (!rst_n) link_q <= 1'b0;
    else        link_q <= link_fast;
  end

  assign ready_pulse = link_fast & ~link_q;
endmodule

// File: rtl/lmr_ctl_snoop.sv
module lmr_ctl_snoop #(
  parameter int CTL_W = lmr_pkg::LMR_CTL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snoop_en,
  input  logic             word_vld,
  input  logic [CTL_W-1:0] word,
  input  logic             stop,
  output logic [CTL_W-1:0] held_q,
  output logic             start_pulse,
  output logic             change_pulse,
  output logic             stop_pulse
);
  logic seen_q;
  logic take_word;

  assign take_word = snoop_en && !stop && word_vld && (!seen_q || (word != held_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q       <= '0;
      seen_q       <= 1'b0;
      start_pulse  <= 1'b0;
      change_pulse <= 1'b0;
      stop_pulse   <= 1'b0;
    end else begin
      start_pulse  <= take_word && !seen_q;
      change_pulse <= take_word && seen_q;
      stop_pulse   <= snoop_en && stop;
      if (!snoop_en || stop) seen_q <= 1'b0;
      else if (take_word)    seen_q <= 1'b1;
      if (take_word) held_q <= word;
    end
  end
endmodule

// File: rtl/lmr_evt_unit.sv
module lmr_evt_unit #(
  parameter int EVT_N = lmr_pkg::LMR_EVT_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_N-1:0] set_vec,
  input  logic [EVT_N-1:0] clr_vec,
  input  logic             mask_we,
  input  logic [EVT_N-1:0] mask_wdata,
  output logic [EVT_N-1:0] raw_q,
  output logic [EVT_N-1:0] mask_q,
  output logic             irq
);
  logic [EVT_N-1:0] raw_d;
  assign raw_d = lmr_pkg::lmr_w1c_next(raw_q, clr_vec, set_vec);

  for (genvar i = 0; i < EVT_N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        raw_q[i]  <= 1'b0;
        mask_q[i] <= 1'b0;
      end else begin
        raw_q[i] <= raw_d[i];
        if (mask_we) mask_q[i] <= mask_wdata[i];
      end
    end
  end

  assign irq = |(raw_q & mask_q);
endmodule

// File: rtl/lane_margin_relay.sv
module lane_margin_relay
  import lmr_pkg::*;
#(
  parameter int ADDR_W = LMR_ADDR_W,
  parameter int DATA_W = LMR_DATA_W,
  parameter int CTL_W  = LMR_CTL_W,
  parameter int STAT_W = LMR_STAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ctl_vld,
  input  logic [CTL_W-1:0]  ctl_word,
  input  logic              ctl_stop,
  input  logic              link_fast,
  output logic              irq,
  output logic [STAT_W-1:0] margin_status
);
  localparam int EVT_N = LMR_EVT_N;

  // named internal events, used by the bound checker
  logic [EVT_N-1:0]  sw_flags_q;
  logic [STAT_W-1:0] mstat_q;
  logic [CTL_W-1:0]  held_ctl;
  logic [EVT_N-1:0]  evt_set;
  logic [EVT_N-1:0]  evt_clr;
  logic [EVT_N-1:0]  evt_raw;
  logic [EVT_N-1:0]  evt_mask;
  logic              snoop_en;
  logic              ready_pulse;
  logic              start_pulse;
  logic              change_pulse;
  logic              stop_pulse;
  logic              wr_mask, wr_raw, wr_flags, wr_mstat;

  assign wr_mask  = bus_wr && (bus_addr == OFS_EVT_MASK);
  assign wr_raw   = bus_wr && (bus_addr == OFS_EVT_RAW);
  assign wr_flags = bus_wr && (bus_addr == OFS_SW_FLAGS);
  assign wr_mstat = bus_wr && (bus_addr == OFS_MSTATUS);
  assign snoop_en = lmr_flags_ready(sw_flags_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_flags_q <= '0;
      mstat_q    <= '0;
    end else begin
      if (wr_flags) sw_flags_q <= bus_wdata[EVT_N-1:0];
      if (wr_mstat) mstat_q    <= bus_wdata[STAT_W-1:0];
    end
  end

  lmr_link_watch u_link (
    .clk         (clk),
    .rst_n       (rst_n),
    .link_fast   (link_fast),
    .ready_pulse (ready_pulse)
  );

  lmr_ctl_snoop #(.CTL_W(CTL_W)) u_snoop (
    .clk          (clk),
    .rst_n        (rst_n),
    .snoop_en     (snoop_en),
    .word_vld     (ctl_vld),
    .word         (ctl_word),
    .stop         (ctl_stop),
    .held_q       (held_ctl),
    .start_pulse  (start_pulse),
    .change_pulse (change_pulse),
    .stop_pulse   (stop_pulse)
  );

  always_comb begin
    evt_set            = '0;
    evt_set[EV_READY]  = ready_pulse;
    evt_set[EV_START]  = start_pulse;
    evt_set[EV_CHANGE] = change_pulse;
    evt_set[EV_STOP]   = stop_pulse;
  end
  assign evt_clr = wr_raw ? bus_wdata[EVT_N-1:0] : '0;

  lmr_evt_unit #(.EVT_N(EVT_N)) u_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_vec    (evt_set),
    .clr_vec    (evt_clr),
    .mask_we    (wr_mask),
    .mask_wdata (bus_wdata[EVT_N-1:0]),
    .raw_q      (evt_raw),
    .mask_q     (evt_mask),
    .irq        (irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_EVT_MASK: bus_rdata[EVT_N-1:0]  = evt_mask;
      OFS_EVT_RAW:  bus_rdata[EVT_N-1:0]  = evt_raw;
      OFS_SW_FLAGS: bus_rdata[EVT_N-1:0]  = sw_flags_q;
      OFS_HELD_CTL: bus_rdata[CTL_W-1:0]  = held_ctl;
      OFS_MSTATUS:  bus_rdata[STAT_W-1:0] = mstat_q;
      default:      bus_rdata = '0;
    endcase
  end

  assign margin_status = mstat_q;
endmodule

// File: rtl/lmr_checker.sv
module lmr_checker #(
  parameter int EVT_N  = lmr_pkg::LMR_EVT_N,
  parameter int CTL_W  = lmr_pkg::LMR_CTL_W,
  parameter int STAT_W = lmr_pkg::LMR_STAT_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              snoop_en,
  input logic              link_fast,
  input logic              wr_mstat,
  input logic [STAT_W-1:0] wdata_lo,
  input logic [STAT_W-1:0] margin_status,
  input logic [CTL_W-1:0]  held_ctl,
  input logic              change_pulse,
  input logic [EVT_N-1:0]  evt_set,
  input logic [EVT_N-1:0]  evt_clr,
  input logic [EVT_N-1:0]  evt_raw,
  input logic [EVT_N-1:0]  evt_mask,
  input logic              irq
);
  AST_HELD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !snoop_en |=> $stable(held_ctl)); // R4
  AST_NO_EVT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !snoop_en |=> (evt_set[3:1] == 3'b000)); // R4
  AST_CHANGE_DIFFERS: assert property (@(posedge clk) disable iff (!rst_n)
    change_pulse |-> (held_ctl != $past(held_ctl))); // R6
  AST_READY_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_fast) |=> evt_raw[0]); // R3
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_set) |=> ((evt_raw & $past(evt_set)) == $past(evt_set))); // R8
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_clr & ~evt_set)) |=> ((evt_raw & $past(evt_clr & ~evt_set)) == '0)); // R8
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((|evt_mask) && (|evt_raw))); // R9
  AST_STATUS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mstat |=> (margin_status == $past(wdata_lo))); // R10
endmodule

bind lane_margin_relay lmr_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .snoop_en      (snoop_en),
  .link_fast     (link_fast),
  .wr_mstat      (wr_mstat),
  .wdata_lo      (bus_wdata[15:0]),
  .margin_status (margin_status),
  .held_ctl      (held_ctl),
  .change_pulse  (change_pulse),
  .evt_set       (evt_set),
  .evt_clr       (evt_clr),
  .evt_raw       (evt_raw),
  .evt_mask      (evt_mask),
  .irq           (irq)
);

// File: tb/lane_margin_relay_tb.sv
module lane_margin_relay_tb;
  import lmr_pkg::*;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ctl_vld = 1'b0;
  logic [22:0] ctl_word = '0;
  logic        ctl_stop = 1'b0;
  logic        link_fast = 1'b0;
  logic        irq;
  logic [15:0] margin_status;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench model of the register state
  logic [3:0]  m_mask = '0, m_raw = '0, m_flags = '0, m_pend = '0;
  logic [22:0] m_held = '0;
  logic [15:0] m_stat = '0;
  logic        m_seen = 1'b0, m_link = 1'b0;
  logic [31:0] obs_rd;
  logic        obs_irq;
  logic [15:0] obs_stat;

  always #(CLK_P/2) clk = ~clk;

  lane_margin_relay u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctl_vld(ctl_vld),
    .ctl_word(ctl_word), .ctl_stop(ctl_stop), .link_fast(link_fast),
    .irq(irq), .margin_status(margin_status)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'hE0: return {28'd0, m_mask};
      8'hE4: return {28'd0, m_raw};
      8'hE8: return {28'd0, m_flags};
      8'hEC: return {9'd0, m_held};
      8'hF0: return {16'd0, m_stat};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string read_req(input logic [7:0] a);
    case (a)
      8'hE0: return "R2";
      8'hE4: return "R8";
      8'hEC: return "R11";
      8'hF0: return "R10";
      default: return "R12";
    endcase
  endfunction

  // one clock: drive at negedge, compare against model, then advance model
  task automatic step(input logic v, input logic [22:0] w, input logic s, input logic l,
                      input logic we, input logic [7:0] a, input logic [31:0] d);
    logic rdy;
    logic take;
    logic [3:0] clr;
    @(negedge clk);
    ctl_vld = v; ctl_word = w; ctl_stop = s; link_fast = l;
    bus_wr = we; bus_addr = a; bus_wdata = d;
    #1;
    obs_rd = bus_rdata; obs_irq = irq; obs_stat = margin_status;
    chk(obs_rd == exp_read(a), read_req(a), obs_rd, exp_read(a));
    chk(obs_irq == |(m_raw & m_mask), "R9", {31'd0, obs_irq}, {31'd0, |(m_raw & m_mask)});
    chk(obs_stat == m_stat, "R10", {16'd0, obs_stat}, {16'd0, m_stat});
    @(posedge clk);
    rdy  = m_flags[0] && m_flags[1];
    take = rdy && !s && v && (!m_seen || w != m_held);
    clr  = (we && a == 8'hE4) ? d[3:0] : 4'd0;
    m_raw = (m_raw & ~clr) | m_pend | {3'd0, l && !m_link};
    m_pend = 4'd0;
    if (rdy && s) m_pend = 4'b1000;
    else if (take) m_pend = m_seen ? 4'b0100 : 4'b0010;
    if (take) m_held = w;
    if (!rdy || s) m_seen = 1'b0;
    else if (take) m_seen = 1'b1;
    m_link = l;
    if (we && a == 8'hE0) m_mask = d[3:0];
    if (we && a == 8'hE8) m_flags = d[3:0];
    if (we && a == 8'hF0) m_stat = d[15:0];
  endtask

  task automatic idle(input logic [7:0] a);
    step(1'b0, '0, 1'b0, link_fast, 1'b0, a, '0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(1'b0, '0, 1'b0, link_fast, 1'b1, a, d);
  endtask

  task automatic send(input logic [22:0] w);
    step(1'b1, w, 1'b0, link_fast, 1'b0, 8'h00, '0);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [22:0] w1, w2, w3, w4;
    logic [22:0] pool [4];
    void'($urandom(32'd2417));
    w1 = lmr_pack(1'b1, 1'b0, 7'h15, 6'h2A, 8'h40);
    w2 = lmr_pack(1'b1, 1'b0, 7'h16, 6'h2A, 8'h40);
    w3 = lmr_pack(1'b0, 1'b1, 7'h7F, 6'h01, 8'hFF);
    w4 = lmr_pack(1'b1, 1'b1, 7'h00, 6'h3F, 8'h01);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset values
    idle(8'hE4); chk(obs_rd == 0 && !obs_irq && obs_stat == 0, "R1", obs_rd, 32'd0);
    idle(8'hEC); chk(obs_rd == 0, "R1", obs_rd, 32'd0);
    // R2 mask register
    wr(8'hE0, 32'hFFFF_FFFF); idle(8'hE0); chk(obs_rd == 32'hF, "R2", obs_rd, 32'hF);
    // R4 word while not ready
    send(w1); idle(8'h00); idle(8'hEC); chk(obs_rd == 0, "R4", obs_rd, 32'd0);
    idle(8'hE4); chk(obs_rd == 0, "R4", obs_rd, 32'd0);
    // R3 readiness
    step(1'b0, '0, 1'b0, 1'b1, 1'b0, 8'h00, '0);
    idle(8'hE4); chk(obs_rd == 32'h1 && obs_irq, "R3", obs_rd, 32'h1);
    // R8 clear
    wr(8'hE4, 32'h1); idle(8'hE4); chk(obs_rd == 0 && !obs_irq, "R8", obs_rd, 32'd0);
    // R12 flags, R5 start one clock after capture
    wr(8'hE8, 32'h3); idle(8'hE8); chk(obs_rd == 32'h3, "R12", obs_rd, 32'h3);
    send(w1);
    idle(8'hEC); chk(obs_rd == {9'd0, w1} && !obs_irq, "R5", obs_rd, {9'd0, w1});
    idle(8'hE4); chk(obs_rd == 32'h2, "R5", obs_rd, 32'h2);
    // R6 identical then different word
    wr(8'hE4, 32'h2); send(w1); idle(8'h00); idle(8'hE4);
    chk(obs_rd == 0, "R6", obs_rd, 32'd0);
    send(w2); idle(8'h00); idle(8'hE4); chk(obs_rd == 32'h4, "R6", obs_rd, 32'h4);
    idle(8'hEC); chk(obs_rd == {9'd0, w2}, "R11", obs_rd, {9'd0, w2});
    // R8 set in same edge as clear
    wr(8'hE4, 32'hF); send(w3); wr(8'hE4, 32'h4);
    idle(8'hE4); chk(obs_rd == 32'h4, "R8", obs_rd, 32'h4);
    // R7 stop wins over a word, then a repeat word counts as start
    wr(8'hE4, 32'hF);
    step(1'b1, w4, 1'b1, 1'b1, 1'b0, 8'h00, '0); idle(8'h00);
    idle(8'hE4); chk(obs_rd == 32'h8, "R7", obs_rd, 32'h8);
    idle(8'hEC); chk(obs_rd == {9'd0, w3}, "R7", obs_rd, {9'd0, w3});
    wr(8'hE4, 32'hF); send(w3); idle(8'h00);
    idle(8'hE4); chk(obs_rd == 32'h2, "R7", obs_rd, 32'h2);
    // R10 status output
    wr(8'hF0, 32'h1234_ABCD); idle(8'hF0);
    chk(obs_stat == 16'hABCD && obs_rd == 32'hABCD, "R10", {16'd0, obs_stat}, 32'hABCD);
    // R11 write ignored, R12 unmapped
    wr(8'hEC, 32'h0); idle(8'hEC); chk(obs_rd == {9'd0, w3}, "R11", obs_rd, {9'd0, w3});
    idle(8'h10); chk(obs_rd == 0, "R12", obs_rd, 32'd0);
    // R4 ready dropped
    wr(8'hE8, 32'h1); send(w4); idle(8'h00); idle(8'hEC);
    chk(obs_rd == {9'd0, w3}, "R4", obs_rd, {9'd0, w3});
    // R9 masked event
    wr(8'hE0, 32'h0); idle(8'hE4);
    chk(obs_rd != 0 && !obs_irq, "R9", {31'd0, obs_irq}, 32'd0);

    // random traffic against the model
    pool[0] = w1; pool[1] = w2; pool[2] = w3; pool[3] = w4;
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      logic [31:0] d;
      logic l;
      case ($urandom % 6)
        0: a = 8'hE0; 1: a = 8'hE4; 2: a = 8'hE8;
        3: a = 8'hEC; 4: a = 8'hF0; default: a = 8'h10;
      endcase
      d = $urandom;
      if (a == 8'hE8 && ($urandom % 4 != 0)) d = 32'h3;
      l = (($urandom % 30) == 0) ? ~link_fast : link_fast;
      step(($urandom % 3) == 0, pool[$urandom % 4], ($urandom % 40) == 0, l,
           ($urandom % 5) == 0, a, d);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule